// File: doc/BRIEF.md
# Flow-Through Zero-Turnaround Synchronous SRAM

This block is a synthesizable, depth-parameterised model of a synchronous flow-through SRAM. Reads and writes can follow each other in any mix on every clock with no idle cycles between them. A command (address, load/advance, write enable, byte selects, chip selects) is captured on a rising clock edge. The data for that command uses the bus during the following cycle. A read drives its word combinationally after the capturing edge. A write supplies its word at the next enabled edge.

Write data is not placed in the array at once. It is parked in a one-entry pending-write register. It is copied into the array only when the next write's data arrives. A read whose address matches the pending entry sees the parked lanes overlaid on the array word, so it always returns the newest data.

A two-bit burst counter steps the low address bits without a new address, in either linear or interleaved order. A clock-enable input freezes the whole block for a cycle. A sleep input turns the bus off and blocks commands while keeping the array contents.

Top module: `ft_sram`

## Requirements
- R1: While `clk_en_n` is high at a rising edge, that edge changes no state (command, burst position, pending write, array), so `dq_o` holds its previous value.
- R2: A load (`adv_ld_n` low) selects the device only when `cs1_n`=0, `cs2`=1 and `cs3_n`=0. Any other combination makes a deselect cycle, which accesses nothing and leaves `dq_oe` low in the next cycle.
- R3: A selected read loaded at edge k drives `dq_oe`=1 (with `oe_n` low) and the addressed word on `dq_o` in the cycle after edge k.
- R4: Write data is taken from `dq_i` at the first enabled edge after the edge that loaded the write. Lane i is bits [i*9+8 : i*9], which include that lane's parity bit. The lane is written only if `bsel_n[i]` was 0 with the command. With all `bsel_n` bits at 1, nothing is written.
- R5: A read of the address held in the pending write register returns the pending lanes merged over the array word.
- R6: Writes and reads alternate on consecutive clocks with no idle cycle, and every read returns correct data.
- R7: With `burst_ilv`=0, each advance (`adv_ld_n` high) sets the low two address bits to (start + n) mod 4, where n is the advance count since the load. The upper address bits are unchanged and the access kind repeats.
- R8: With `burst_ilv`=1, the n-th advance sets the low two address bits to start XOR n.
- R9: An advance ignores the chip selects and `wr_n`. An advance that follows a deselect stays deselected.
- R10: `dq_oe` is low during the data cycle of a write. It also falls in the same cycle whenever `oe_n` is high, without waiting for a clock.
- R11: While `sleep` is high, `dq_oe` is low and no command is accepted. The first two rising edges after `sleep` falls also accept no command. The array keeps its contents throughout. The sleep and recovery count runs on every edge, whatever `clk_en_n` is.
- R12: After reset the block is deselected, `dq_oe` is low and no write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en_n | input | 1 | Active-low clock qualifier; high freezes the cycle |
| adv_ld_n | input | 1 | Low: load new command; high: advance burst |
| addr | input | ADDR_W | Word address |
| wr_n | input | 1 | Low: write, high: read (on a load) |
| bsel_n | input | LANES | Active-low per-lane write selects |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| burst_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| oe_n | input | 1 | Asynchronous active-low output enable |
| sleep | input | 1 | Low-power hold; bus off, contents kept |
| dq_i | input | LANES*LANE_W | Write data in |
| dq_o | output | LANES*LANE_W | Read data out |
| dq_oe | output | 1 | Tri-state control for the data bus |

## Verification
Every command's result is due one edge after the edge that captured it. The bench changes inputs 2 ns after a rising edge and checks `dq_o` and `dq_oe` at that same point, so the result of the command just captured is the one checked. Write data is applied together with the following command, so each write lands one clock late, as the requirements state. The enable gating by `oe_n` and `sleep` is combinational, so it is checked 1 ns after the input changes, with no clock edge between.

// File: rtl/ft_sram_pkg.sv
package ft_sram_pkg;
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;
endpackage

// File: rtl/ft_burst_seq.sv
module ft_burst_seq #(
    parameter int CW = 2
) (
    input  logic [CW-1:0] start,
    input  logic [CW-1:0] step,
    input  logic          ilv,
    output logic [CW-1:0] offs
);
    // interleaved order flips bits of the start offset; linear order adds with wrap
    always_comb begin
        if (ilv) offs = start ^ step;
        else     offs = start + step;
    end
endmodule

// File: rtl/ft_lane_merge.sv
module ft_lane_merge #(
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic [LANES*LANE_W-1:0] base,
    input  logic [LANES*LANE_W-1:0] upd,
    input  logic [LANES-1:0]        take,
    output logic [LANES*LANE_W-1:0] merged
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign merged[i*LANE_W +: LANE_W] = take[i] ? upd[i*LANE_W +: LANE_W]
                                                    : base[i*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/ft_sram.sv
module ft_sram
    import ft_sram_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int LANES   = 2,
    parameter int LANE_W  = 9,
    parameter int REC_CYC = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clk_en_n,
    input  logic                    adv_ld_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    wr_n,
    input  logic [LANES-1:0]        bsel_n,
    input  logic                    cs1_n,
    input  logic                    cs2,
    input  logic                    cs3_n,
    input  logic                    burst_ilv,
    input  logic                    oe_n,
    input  logic                    sleep,
    input  logic [LANES*LANE_W-1:0] dq_i,
    output logic [LANES*LANE_W-1:0] dq_o,
    output logic                    dq_oe
);
    localparam int DATA_W = LANES * LANE_W;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int BC_W   = 2;
    localparam int RC_W   = $clog2(REC_CYC + 1);

    typedef struct packed {
        op_e                op;
        logic [ADDR_W-1:0]  a;
        logic [BC_W-1:0]    start;
        logic [BC_W-1:0]    cnt;
        logic [LANES-1:0]   we;
        logic               pv;
        logic [ADDR_W-1:0]  pa;
        logic [DATA_W-1:0]  pd;
        logic [LANES-1:0]   pm;
        logic [RC_W-1:0]    rec;
    } st_t;

    st_t s_q, s_d;

    logic [DATA_W-1:0] mem [DEPTH];

    logic [BC_W-1:0]   cnt_nx;
    logic [BC_W-1:0]   off_nx;
    logic              sel;
    logic              blocked;
    logic              commit;
    logic [DATA_W-1:0] cmt_word;
    logic [DATA_W-1:0] rd_base;
    logic [LANES-1:0]  rd_take;

    assign cnt_nx  = s_q.cnt + BC_W'(1);
    assign sel     = !cs1_n && cs2 && !cs3_n;
    assign blocked = sleep || (s_q.rec != '0);

    ft_burst_seq #(.CW(BC_W)) u_seq (
        .start (s_q.start),
        .step  (cnt_nx),
        .ilv   (burst_ilv),
        .offs  (off_nx)
    );

    // next-state computation
    always_comb begin
        s_d    = s_q;
        commit = 1'b0;
        if (!clk_en_n) begin
            // data phase of the write captured one edge earlier: park it, retire the older one
            if (s_q.op == OP_WRITE) begin
                commit = s_q.pv;
                s_d.pv = 1'b1;
                s_d.pa = s_q.a;
                s_d.pd = dq_i;
                s_d.pm = s_q.we;
            end
            if (blocked) begin
                s_d.op = OP_NONE;
            end else if (!adv_ld_n) begin
                s_d.op    = !sel ? OP_NONE : (wr_n ? OP_READ : OP_WRITE);
                s_d.a     = addr;
                s_d.start = addr[BC_W-1:0];
                s_d.cnt   = '0;
                s_d.we    = ~bsel_n;
            end else begin
                s_d.cnt = cnt_nx;
                s_d.a   = {s_q.a[ADDR_W-1:BC_W], off_nx};
                s_d.we  = ~bsel_n;
            end
        end
        // sleep recovery counter runs on every edge
        if (sleep)                s_d.rec = RC_W'(REC_CYC);
        else if (s_q.rec != '0)   s_d.rec = s_q.rec - RC_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // array retirement of the older pending write
    ft_lane_merge #(.LANES(LANES), .LANE_W(LANE_W)) u_cmt (
        .base   (mem[s_q.pa]),
        .upd    (s_q.pd),
        .take   (s_q.pm),
        .merged (cmt_word)
    );

    always_ff @(posedge clk) begin
        if (commit) mem[s_q.pa] <= cmt_word;
    end

    // read path with forwarding from the pending register
    assign rd_base = mem[s_q.a];
    assign rd_take = (s_q.pv && (s_q.pa == s_q.a)) ? s_q.pm : '0;

    ft_lane_merge #(.LANES(LANES), .LANE_W(LANE_W)) u_fwd (
        .base   (rd_base),
        .upd    (s_q.pd),
        .take   (rd_take),
        .merged (dq_o)
    );

    assign dq_oe = (s_q.op == OP_READ) && !oe_n && !sleep;
endmodule

// File: rtl/ft_sram_chk.sv
module ft_sram_chk #(
    parameter int DATA_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clk_en_n,
    input logic              adv_ld_n,
    input logic              wr_n,
    input logic              cs1_n,
    input logic              cs2,
    input logic              cs3_n,
    input logic              oe_n,
    input logic              sleep,
    input logic [DATA_W-1:0] dq_o,
    input logic              dq_oe
);
    // frozen edge leaves read data unchanged
    p_freeze_r1: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n |=> $stable(dq_o));

    // a deselecting load never drives the bus in its data cycle
    p_desel_hiz_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !adv_ld_n && (cs1_n || !cs2 || cs3_n)) |=> !dq_oe);

    // write data cycle keeps drivers off
    p_wr_hiz_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !adv_ld_n && !wr_n) |=> !dq_oe);

    // output enable gates the drivers
    p_oe_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dq_oe);

    // sleep keeps the bus off
    p_sleep_hiz_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !dq_oe);
endmodule

bind ft_sram ft_sram_chk #(.DATA_W(LANES*LANE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en_n (clk_en_n),
    .adv_ld_n (adv_ld_n),
    .wr_n     (wr_n),
    .cs1_n    (cs1_n),
    .cs2      (cs2),
    .cs3_n    (cs3_n),
    .oe_n     (oe_n),
    .sleep    (sleep),
    .dq_o     (dq_o),
    .dq_oe    (dq_oe)
);

// File: tb/tb_ft_sram.sv
module tb_ft_sram;
    localparam int AW = 6;
    localparam int L  = 2;
    localparam int LW = 9;
    localparam int DW = L * LW;
    localparam int VW = 2 + AW + L + DW + 1 + DW;
    localparam int NV = 10;

    // op(2) addr(6) bsel_n(2) wdata(18) exp_oe(1) exp_data(18); op 0 deselect, 1 read, 2 write
    localparam logic [VW-1:0] TBL [NV] = '{
        {2'd2, 6'd5, 2'b00, 18'h00000, 1'b0, 18'h00000},
        {2'd2, 6'd6, 2'b00, 18'h11111, 1'b0, 18'h00000},
        {2'd1, 6'd5, 2'b00, 18'h22222, 1'b1, 18'h11111},
        {2'd1, 6'd6, 2'b00, 18'h00000, 1'b1, 18'h22222},
        {2'd2, 6'd6, 2'b01, 18'h00000, 1'b0, 18'h00000},
        {2'd1, 6'd6, 2'b00, 18'h3FFFF, 1'b1, 18'h3FE22},
        {2'd2, 6'd5, 2'b11, 18'h00000, 1'b0, 18'h00000},
        {2'd1, 6'd5, 2'b00, 18'h15555, 1'b1, 18'h11111},
        {2'd0, 6'd5, 2'b00, 18'h00000, 1'b0, 18'h00000},
        {2'd1, 6'd6, 2'b00, 18'h00000, 1'b1, 18'h3FE22}
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          clk_en_n, adv_ld_n, wr_n, cs1_n, cs2, cs3_n;
    logic          burst_ilv, oe_n, sleep;
    logic [AW-1:0] addr;
    logic [L-1:0]  bsel_n;
    logic [DW-1:0] dq_i, dq_o;
    logic          dq_oe;
    int            n_chk = 0;
    int            n_bad = 0;

    always #4 clk = ~clk;

    ft_sram #(.ADDR_W(AW), .LANES(L), .LANE_W(LW), .REC_CYC(2)) dut (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .adv_ld_n(adv_ld_n),
        .addr(addr), .wr_n(wr_n), .bsel_n(bsel_n), .cs1_n(cs1_n), .cs2(cs2),
        .cs3_n(cs3_n), .burst_ilv(burst_ilv), .oe_n(oe_n), .sleep(sleep),
        .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // apply one command (ld=1 load, ld=0 advance) plus data for the previous write, then cross an edge
    task automatic step(input bit ld, input bit wr, input logic [AW-1:0] a,
                        input logic [L-1:0] bn, input logic [DW-1:0] wd,
                        input logic [2:0] csv);
        adv_ld_n = !ld;
        wr_n     = !wr;
        addr     = a;
        bsel_n   = bn;
        dq_i     = wd;
        {cs1_n, cs2, cs3_n} = csv;
        @(posedge clk);
        #2;
    endtask

    task automatic expect_rd(input string tag, input logic [DW-1:0] d);
        chk({tag, " oe"}, 32'(dq_oe), 32'd1);
        chk({tag, " data"}, 32'(dq_o), 32'(d));
    endtask

    localparam logic [2:0] SEL = 3'b010;

    initial begin
        #(8 * 20000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; clk_en_n = 1'b0; adv_ld_n = 1'b0; wr_n = 1'b1;
        cs1_n = 1'b1; cs2 = 1'b1; cs3_n = 1'b0; burst_ilv = 1'b0;
        oe_n = 1'b0; sleep = 1'b0; addr = '0; bsel_n = '1; dq_i = '0;
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        // R12: reset state
        chk("R12 reset oe", 32'(dq_oe), 32'd0);
        step(1'b1, 1'b0, 6'd0, 2'b11, '0, 3'b110);
        chk("R12 idle after reset", 32'(dq_oe), 32'd0);

        // R6 / R5 / R4 / R3 / R2 table: interleaved writes and reads
        for (int i = 0; i < NV; i++) begin
            logic [1:0]    op;
            logic [AW-1:0] va;
            logic [L-1:0]  vb;
            logic [DW-1:0] vw, vd;
            logic          vo;
            {op, va, vb, vw, vo, vd} = TBL[i];
            step(1'b1, op == 2'd2, va, vb, vw, (op == 2'd0) ? 3'b110 : SEL);
            chk($sformatf("R6 R3 vec%0d oe", i), 32'(dq_oe), 32'(vo));
            if (vo) chk($sformatf("R5 R4 vec%0d data", i), 32'(dq_o), 32'(vd));
        end

        // R2: other deselect patterns
        step(1'b1, 1'b0, 6'd5, 2'b00, '0, 3'b000);
        chk("R2 cs2 low", 32'(dq_oe), 32'd0);
        step(1'b1, 1'b0, 6'd5, 2'b00, '0, 3'b011);
        chk("R2 cs3_n high", 32'(dq_oe), 32'd0);

        // fill 8..11 back to back
        step(1'b1, 1'b1, 6'd8,  2'b00, '0,        SEL);
        step(1'b1, 1'b1, 6'd9,  2'b00, 18'h0A008, SEL);
        step(1'b1, 1'b1, 6'd10, 2'b00, 18'h0A009, SEL);
        step(1'b1, 1'b1, 6'd11, 2'b00, 18'h0A00A, SEL);
        // R7 linear burst from offset 2; R9 advances with selects off and wr_n low
        step(1'b1, 1'b0, 6'd10, 2'b00, 18'h0A00B, SEL);
        expect_rd("R7 lin0", 18'h0A00A);
        step(1'b0, 1'b1, 6'd0, 2'b00, '0, 3'b101);
        expect_rd("R7 R9 lin1", 18'h0A00B);
        step(1'b0, 1'b1, 6'd0, 2'b00, '0, 3'b101);
        expect_rd("R7 lin2", 18'h0A008);
        step(1'b0, 1'b0, 6'd0, 2'b00, '0, SEL);
        expect_rd("R7 lin3", 18'h0A009);

        // R8 interleaved burst from offset 1
        burst_ilv = 1'b1;
        step(1'b1, 1'b0, 6'd9, 2'b00, '0, SEL);
        expect_rd("R8 ilv0", 18'h0A009);
        step(1'b0, 1'b0, 6'd0, 2'b00, '0, SEL);
        expect_rd("R8 ilv1", 18'h0A008);
        step(1'b0, 1'b0, 6'd0, 2'b00, '0, SEL);
        expect_rd("R8 ilv2", 18'h0A00B);
        step(1'b0, 1'b0, 6'd0, 2'b00, '0, SEL);
        expect_rd("R8 ilv3", 18'h0A00A);
        burst_ilv = 1'b0;

        // R1 frozen edges: a load and an advance are both ignored
        clk_en_n = 1'b1;
        step(1'b1, 1'b0, 6'd8, 2'b00, '0, SEL);
        expect_rd("R1 frozen load", 18'h0A00A);
        step(1'b0, 1'b0, 6'd8, 2'b00, '0, SEL);
        expect_rd("R1 frozen adv", 18'h0A00A);
        clk_en_n = 1'b0;

        // R9 advance after deselect remains deselected
        step(1'b1, 1'b0, 6'd8, 2'b00, '0, 3'b110);
        step(1'b0, 1'b0, 6'd8, 2'b00, '0, SEL);
        chk("R9 adv after deselect", 32'(dq_oe), 32'd0);

        // R10 asynchronous output enable
        step(1'b1, 1'b0, 6'd8, 2'b00, '0, SEL);
        expect_rd("R10 read before oe", 18'h0A008);
        oe_n = 1'b1;
        #1;
        chk("R10 oe_n high", 32'(dq_oe), 32'd0);
        oe_n = 1'b0;
        #1;
        chk("R10 oe_n low again", 32'(dq_oe), 32'd1);

        // R11 sleep, recovery and retention
        sleep = 1'b1;
        #1;
        chk("R11 sleep hiz", 32'(dq_oe), 32'd0);
        step(1'b1, 1'b0, 6'd9, 2'b00, '0, SEL);
        chk("R11 read during sleep", 32'(dq_oe), 32'd0);
        sleep = 1'b0;
        step(1'b1, 1'b0, 6'd9, 2'b00, '0, SEL);
        chk("R11 recovery edge1", 32'(dq_oe), 32'd0);
        step(1'b1, 1'b0, 6'd9, 2'b00, '0, SEL);
        chk("R11 recovery edge2", 32'(dq_oe), 32'd0);
        step(1'b1, 1'b0, 6'd9, 2'b00, '0, SEL);
        expect_rd("R11 retained", 18'h0A009);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule